// File: doc/BRIEF.md
# Block Write-Protect Lock Manager

This block holds the write-protection state of every erase block in a flash array. Each block is in one of three states: open for writing, locked, or locked-tight. A locked-tight block cannot be opened or relocked again until the next cold reset. Software loads a first-block and a last-block register and then issues one of four range commands. The block carries out a command by walking the selected blocks one per clock. Program and erase logic reads any block's state through a combinational query port.

Each accepted command raises an interrupt-pending flag. While that flag is set, further commands are ignored, until the host clears it. Every block that a walk rewrites also copies its new state into a write-protect status output. The walk is reported through a busy level and a one-cycle done pulse.

The block count is a parameter and must be a power of two.

Top module: `wp_lock_mgr`

## Requirements
- R1: After reset, the following hold. Every block reads locked. The states are one-hot coded: locked-tight = 3'b001, locked = 3'b010, open = 3'b100. `wp_status` is 3'b010. `range_start` and `range_end` are 0. `busy`, `done` and `int_pend` are low.
- R2: A pulse on `start_we` stores `wr_data & (NUM_BLK-1)` into both `range_start` and `range_end`. A pulse on `end_we` alone updates only `range_end`, with the same masking.
- R3: Code 8'h23 walks from `range_start` to `range_end` inclusive, in ascending order, and sets each block to open. The walk stops at the first locked-tight block and leaves that block unchanged.
- R4: Code 8'h27 walks every block from index 0 upward and sets each to open. It stops at the first locked-tight block and leaves that block unchanged.
- R5: Code 8'h2A walks the range in the same way as R3, but sets each block to locked. It also stops at the first locked-tight block.
- R6: Code 8'h2C walks the whole range. It leaves open blocks untouched and sets every other block to locked-tight.
- R7: When `range_start` is greater than `range_end`, a range command changes no block. It still completes with a done pulse.
- R8: Each block update copies the new state into `wp_status`. `wp_status` keeps its value when no block is updated.
- R9: An accepted command sets `int_pend`. `int_pend` stays set until an `int_clr` pulse. A command presented while `int_pend` is set, or while `busy` is high, is ignored.
- R10: A `cmd_valid` carrying any other code is ignored. It does not assert `busy`, sets no flag and changes no block.
- R11: `busy` rises in the cycle after a command is accepted. `done` is a single-cycle pulse, with `busy` still high, in the cycle after the last block evaluation. The number of cycles from acceptance to `done` equals the number of block indices evaluated. This number includes the locked-tight block at which a walk stops, and it is 1 for an empty range. `busy` falls in the cycle after `done`.
- R12: `q_state` shows the state of block `q_blk` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| start_we | input | 1 | Write `wr_data` to the first-block and last-block registers |
| end_we | input | 1 | Write `wr_data` to the last-block register only |
| wr_data | input | DATA_W | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| int_clr | input | 1 | Clears the interrupt-pending flag |
| q_blk | input | ADDR_W | Query block index |
| q_state | output | 3 | One-hot state of the queried block |
| range_start | output | ADDR_W | First block of the range |
| range_end | output | ADDR_W | Last block of the range |
| wp_status | output | 3 | State last written by a walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk completion pulse |
| int_pend | output | 1 | Interrupt-pending flag |

## Verification
Several properties are checked on every cycle:
- `wp_status` and `q_state` stay one-hot.
- The range registers follow the writes.
- `done` is a single pulse inside `busy`.
- `wp_status` is frozen while idle.
- Commands are refused while the interrupt flag is pending or the code is unknown.

Some behaviour only the bench scenarios can show. This covers the exact block-by-block result of each walk, including early stops at a locked-tight block, and the skipping of open blocks by the locked-tight command. It also covers the walk latency and the empty-range case. The bench sweeps every start and end pair of an eight-block configuration against all four commands, each time with a locked-tight block placed at a different index.

// File: rtl/wplk_pkg.sv
package wplk_pkg;
  typedef enum logic [2:0] {
    PS_TIGHT  = 3'b001,
    PS_LOCKED = 3'b010,
    PS_OPEN   = 3'b100
  } prot_e;

  localparam logic [7:0] OP_OPEN_RANGE  = 8'h23;
  localparam logic [7:0] OP_OPEN_ALL    = 8'h27;
  localparam logic [7:0] OP_LOCK_RANGE  = 8'h2A;
  localparam logic [7:0] OP_TIGHT_RANGE = 8'h2C;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_WALK = 2'd1,
    W_FIN  = 2'd2
  } wstate_e;
endpackage

// File: rtl/wplk_range_regs.sv
module wplk_range_regs #(
  parameter  int NUM_BLK = 16,
  parameter  int DATA_W  = 16,
  localparam int ADDR_W  = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_we,
  input  logic              end_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] range_start,
  output logic [ADDR_W-1:0] range_end
);
  logic [ADDR_W-1:0] wr_masked;
  logic [ADDR_W-1:0] start_d, end_d, start_q, end_q;
  logic              start_en, end_en;

  always_comb begin
    wr_masked = ADDR_W'(wr_data & DATA_W'(NUM_BLK - 1));
    start_en  = start_we;
    end_en    = start_we | end_we;
    start_d   = wr_masked;
    end_d     = wr_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (end_en)   end_q   <= end_d;
    end
  end

  assign range_start = start_q;
  assign range_end   = end_q;
endmodule

// File: rtl/wplk_state_array.sv
module wplk_state_array import wplk_pkg::*; #(
  parameter  int NUM_BLK = 16,
  localparam int ADDR_W  = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] walk_idx,
  input  logic [2:0]        upd_val,
  output logic [2:0]        walk_state,
  input  logic [ADDR_W-1:0] q_blk,
  output logic [2:0]        q_state
);
  logic [2:0] blk_q [NUM_BLK];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic blk_en;
    assign blk_en = upd_en && (walk_idx == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_q[i] <= PS_LOCKED;
      else if (blk_en) blk_q[i] <= upd_val;
    end
  end

  assign walk_state = blk_q[walk_idx];
  assign q_state    = blk_q[q_blk];
endmodule

// File: rtl/wplk_walker.sv
module wplk_walker import wplk_pkg::*; #(
  parameter  int NUM_BLK = 16,
  localparam int ADDR_W  = $clog2(NUM_BLK),
  localparam int IDX_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              int_clr,
  input  logic [ADDR_W-1:0] range_start,
  input  logic [ADDR_W-1:0] range_end,
  input  logic [2:0]        cur_state,
  output logic [ADDR_W-1:0] walk_idx,
  output logic              upd_en,
  output logic [2:0]        upd_val,
  output logic              busy,
  output logic              done,
  output logic              int_pend,
  output logic [2:0]        wp_status
);
  wstate_e          state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [7:0]       op_q, op_d;
  logic             pend_q, pend_d;
  logic [2:0]       wp_q, wp_d;
  logic             code_ok, accept, in_range, at_last, advance;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    last_d   = last_q;
    op_d     = op_q;
    pend_d   = pend_q;
    upd_en   = 1'b0;
    upd_val  = cur_state;
    advance  = 1'b0;
    code_ok  = (cmd_code == OP_OPEN_RANGE) || (cmd_code == OP_OPEN_ALL) ||
               (cmd_code == OP_LOCK_RANGE) || (cmd_code == OP_TIGHT_RANGE);
    accept   = (state_q == W_IDLE) && cmd_valid && !pend_q && code_ok;
    in_range = (idx_q <= last_q) && (idx_q < IDX_W'(NUM_BLK));
    at_last  = (idx_q == last_q);
    if (int_clr) pend_d = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (accept) begin
          op_d    = cmd_code;
          pend_d  = 1'b1;
          state_d = W_WALK;
          if (cmd_code == OP_OPEN_ALL) begin
            idx_d  = '0;
            last_d = IDX_W'(NUM_BLK - 1);
          end else begin
            idx_d  = {1'b0, range_start};
            last_d = {1'b0, range_end};
          end
        end
      end
      W_WALK: begin
        if (!in_range) begin
          state_d = W_FIN;
        end else if (op_q == OP_TIGHT_RANGE) begin
          if (cur_state != PS_OPEN) begin
            upd_en  = 1'b1;
            upd_val = PS_TIGHT;
          end
          advance = 1'b1;
        end else if (cur_state == PS_TIGHT) begin
          state_d = W_FIN;
        end else begin
          upd_en  = 1'b1;
          upd_val = (op_q == OP_LOCK_RANGE) ? PS_LOCKED : PS_OPEN;
          advance = 1'b1;
        end
        if (advance) begin
          if (at_last) state_d = W_FIN;
          else         idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = W_IDLE;
    endcase
    wp_d = upd_en ? upd_val : wp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      op_q    <= '0;
      pend_q  <= 1'b0;
      wp_q    <= PS_LOCKED;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      op_q    <= op_d;
      pend_q  <= pend_d;
      wp_q    <= wp_d;
    end
  end

  assign walk_idx  = idx_q[ADDR_W-1:0];
  assign busy      = (state_q != W_IDLE);
  assign done      = (state_q == W_FIN);
  assign int_pend  = pend_q;
  assign wp_status = wp_q;
endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr #(
  parameter  int NUM_BLK = 16,
  parameter  int DATA_W  = 16,
  localparam int ADDR_W  = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_we,
  input  logic              end_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              int_clr,
  input  logic [ADDR_W-1:0] q_blk,
  output logic [2:0]        q_state,
  output logic [ADDR_W-1:0] range_start,
  output logic [ADDR_W-1:0] range_end,
  output logic [2:0]        wp_status,
  output logic              busy,
  output logic              done,
  output logic              int_pend
);
  logic [ADDR_W-1:0] walk_idx;
  logic              upd_en;
  logic [2:0]        upd_val, walk_state;

  wplk_range_regs #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
    .wr_data(wr_data), .range_start(range_start), .range_end(range_end)
  );

  wplk_walker #(.NUM_BLK(NUM_BLK)) u_walk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .int_clr(int_clr), .range_start(range_start), .range_end(range_end),
    .cur_state(walk_state), .walk_idx(walk_idx), .upd_en(upd_en),
    .upd_val(upd_val), .busy(busy), .done(done), .int_pend(int_pend),
    .wp_status(wp_status)
  );

  wplk_state_array #(.NUM_BLK(NUM_BLK)) u_arr (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .walk_idx(walk_idx),
    .upd_val(upd_val), .walk_state(walk_state), .q_blk(q_blk),
    .q_state(q_state)
  );
endmodule

// File: rtl/wplk_chk.sv
module wplk_chk import wplk_pkg::*; #(
  parameter  int NUM_BLK = 16,
  parameter  int DATA_W  = 16,
  localparam int ADDR_W  = $clog2(NUM_BLK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_we,
  input logic              end_we,
  input logic [DATA_W-1:0] wr_data,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic              int_clr,
  input logic [ADDR_W-1:0] q_blk,
  input logic [2:0]        q_state,
  input logic [ADDR_W-1:0] range_start,
  input logic [ADDR_W-1:0] range_end,
  input logic [2:0]        wp_status,
  input logic              busy,
  input logic              done,
  input logic              int_pend
);
  logic known;
  assign known = (cmd_code == OP_OPEN_RANGE) || (cmd_code == OP_OPEN_ALL) ||
                 (cmd_code == OP_LOCK_RANGE) || (cmd_code == OP_TIGHT_RANGE);

  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R8
  wp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wp_status));
  // R12
  q_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(q_state));
  // R2
  start_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> (range_start == $past(wr_data[ADDR_W-1:0])) &&
                 (range_end == $past(wr_data[ADDR_W-1:0])));
  // R2
  end_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_we && !start_we) |=> (range_end == $past(wr_data[ADDR_W-1:0])) &&
                              $stable(range_start));
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && !int_clr) |=> int_pend);
  // R9
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && int_pend) |=> !busy);
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !int_pend && cmd_valid && known) |=> busy && int_pend);
  // R10
  unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !known) |=> !busy);
  // R8
  wp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(wp_status));
endmodule

bind wp_lock_mgr wplk_chk #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_wp_lock_mgr.sv
`timescale 1ns/1ps
module test_wp_lock_mgr;
  localparam int N = 8;
  localparam int AW = 3;
  localparam logic [2:0] TIGHT = 3'b001, LOCKED = 3'b010, OPEN = 3'b100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_we = 1'b0, end_we = 1'b0, cmd_valid = 1'b0, int_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0] cmd_code = '0;
  logic [AW-1:0] q_blk = '0;
  logic [2:0] q_state, wp_status;
  logic [AW-1:0] range_start, range_end;
  logic busy, done, int_pend;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [2:0] exp_blk [N];
  logic [2:0] exp_wp;
  int exp_s = 0, exp_e = 0;

  always #5 clk = ~clk;

  wp_lock_mgr #(.NUM_BLK(N), .DATA_W(16)) i_wp_lock_mgr (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .int_clr(int_clr), .q_blk(q_blk), .q_state(q_state),
    .range_start(range_start), .range_end(range_end), .wp_status(wp_status),
    .busy(busy), .done(done), .int_pend(int_pend)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) exp_blk[i] = LOCKED;
    exp_wp = LOCKED;
    exp_s = 0;
    exp_e = 0;
  endtask

  task automatic check_blocks(input string tag);
    for (int i = 0; i < N; i++) begin
      q_blk = AW'(i);
      @(negedge clk);
      chk(q_state == exp_blk[i], tag, q_state, exp_blk[i]);
    end
  endtask

  task automatic write_start(input logic [15:0] v);
    @(negedge clk);
    wr_data = v; start_we = 1'b1;
    @(negedge clk);
    start_we = 1'b0;
    exp_s = int'(v & 16'(N - 1));
    exp_e = exp_s;
  endtask

  task automatic write_end(input logic [15:0] v);
    @(negedge clk);
    wr_data = v; end_we = 1'b1;
    @(negedge clk);
    end_we = 1'b0;
    exp_e = int'(v & 16'(N - 1));
  endtask

  task automatic clear_int();
    @(negedge clk);
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
  endtask

  // issue a known command, model it, check latency, done, wp_status and blocks
  task automatic run_cmd(input logic [7:0] code, input string tag, input bit full);
    int lo, hi, n_eval, cnt;
    logic [2:0] nv;
    bit stop;
    lo = (code == 8'h27) ? 0 : exp_s;
    hi = (code == 8'h27) ? N - 1 : exp_e;
    nv = (code == 8'h2A) ? LOCKED : OPEN;
    n_eval = 0;
    stop = 1'b0;
    if (lo > hi) n_eval = 1;
    else begin
      for (int i = lo; i <= hi && !stop; i++) begin
        n_eval++;
        if (code == 8'h2C) begin
          if (exp_blk[i] != OPEN) begin
            exp_blk[i] = TIGHT;
            exp_wp = TIGHT;
          end
        end else if (exp_blk[i] == TIGHT) stop = 1'b1;
        else begin
          exp_blk[i] = nv;
          exp_wp = nv;
        end
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    // R11 latency equals evaluated indices
    chk(cnt == n_eval, {tag, " R11 latency"}, cnt, n_eval);
    chk(busy == 1'b1, {tag, " R11 busy with done"}, busy, 1);
    chk(int_pend == 1'b1, {tag, " R9 pending set"}, int_pend, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R11 done single"}, {done, busy}, 0);
    // R8 status mirrors last update
    chk(wp_status == exp_wp, {tag, " R8 wp_status"}, wp_status, exp_wp);
    if (full) check_blocks(tag);
    clear_int();
    chk(int_pend == 1'b0, {tag, " R9 pending cleared"}, int_pend, 0);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(busy == 0 && done == 0 && int_pend == 0, "R1 flags", {busy, done, int_pend}, 0);
    chk(wp_status == LOCKED, "R1 wp_status", wp_status, LOCKED);
    chk(range_start == 0 && range_end == 0, "R1 range", {range_start, range_end}, 0);
    check_blocks("R1 blocks");

    // R2 masking and end-only writes
    write_start(16'hFFFD);
    chk(range_start == 3'd5 && range_end == 3'd5, "R2 start write", {range_start, range_end}, 8'h55);
    write_end(16'h0102);
    chk(range_start == 3'd5 && range_end == 3'd2, "R2 end write", {range_start, range_end}, 8'h52);

    // R7 empty range: start 5 > end 2
    run_cmd(8'h23, "R7 empty open", 1'b1);

    // R10 unknown code ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h99;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 0 && int_pend == 0, "R10 unknown code", {busy, int_pend}, 0);
    check_blocks("R10 blocks kept");

    // R9 command ignored while pending
    write_start(16'd1); write_end(16'd6);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h27;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    for (int i = 0; i < N; i++) exp_blk[i] = OPEN;
    exp_wp = OPEN;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h2A;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 0, "R9 ignore while pending", busy, 0);
    check_blocks("R9 blocks kept");
    clear_int();

    // sweep: all range pairs, all ops, tight block at varying index
    for (int s = 0; s < N; s++) begin
      for (int e = 0; e < N; e++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] op;
          int t;
          op = (k == 0) ? 8'h23 : (k == 1) ? 8'h27 : (k == 2) ? 8'h2A : 8'h2C;
          t = (s * 3 + e + k) % N;
          do_reset();
          write_start(16'(t));
          run_cmd(8'h2C, "R6 setup tight", 1'b0);
          run_cmd(8'h27, "R4 setup open all", 1'b0);
          write_start(16'(s));
          write_end(16'(e));
          case (k)
            0: run_cmd(op, "R3 open range", 1'b1);
            1: run_cmd(op, "R4 open all", 1'b1);
            2: run_cmd(op, "R5 lock range", 1'b1);
            default: run_cmd(op, "R6 tight range R12", 1'b1);
          endcase
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule